// File: doc/BRIEF.md
# NAND Page ECC Parity Generator

This block computes error-correction parity on the fly while data bytes stream through a NAND flash controller. Every byte strobe folds all bits of the byte into a pair of parity words in a single clock. One word gathers the addresses of the set bits, and the other gathers the bitwise complement of those addresses. A bit address is the byte's position within a 256-byte chunk followed by the bit's position within the byte.

The page-mode select picks 256-byte or 512-byte operation. In 512-byte mode, the second 256 bytes build their own word pair, so a page yields four words. In 256-byte mode every byte goes to the first pair and the second pair stays zero. A synchronous clear input empties all parity state and the internal byte position before a new page. The words hold their value between strobes, so logic outside the block can read them at leisure.

Logic outside the block packs each pair into three stored ECC bytes and performs the correction. When one data bit is flipped, the two syndromes of its chunk XOR to all ones. The true-address syndrome then gives the byte index and the bit index of the flipped bit.

Top module: `nand_ecc_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `clr_i` is sampled high, all four parity words read zero and the byte position returns to 0.
- R2: For each set bit at bit position j (0..7) of the byte at index i (0..255) within its chunk, the true word of that chunk XORs in the 11-bit value {i[7:0], j[2:0]}. Bits [10:3] carry the byte index and bits [2:0] carry the bit position.
- R3: For each such set bit, the complement word of the chunk XORs in the bitwise inverse of {i, j} over 11 bits.
- R4: With `big_page_i` = 1, strobes 0..255 after a clear update only `lo_true_o`/`lo_comp_o`. Strobes 256..511 update only `hi_true_o`/`hi_comp_o`, and use index = position - 256.
- R5: With `big_page_i` = 0, every strobe updates only the low pair with index = position mod 256, and the high pair stays zero.
- R6: The effect of a byte strobe is visible one clock after the edge that samples it. With neither strobe nor clear, all words and the byte position keep their values.
- R7: A clear sampled together with a strobe wins. That byte is discarded, and the next strobe uses index 0.
- R8: Flipping one data bit at byte i, bit j changes the true word of its chunk by exactly {i, j}. The XOR of the changes in the true and complement words is 0x7FF.
- R9: The byte position counts strobes modulo 512. After 512 strobes, the next byte is index 0 of the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all parity state |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Data byte |
| big_page_i | input | 1 | 1: 512-byte page, 0: 256-byte page |
| lo_true_o | output | 11 | True-address word, first chunk |
| lo_comp_o | output | 11 | Complement-address word, first chunk |
| hi_true_o | output | 11 | True-address word, second chunk |
| hi_comp_o | output | 11 | Complement-address word, second chunk |

## Verification
A wrong byte position shows up in bits [10:3] of a true word one clock after the next strobe whose byte has an odd number of set bits. A wrong position can also send a byte into the wrong half, which the stability checks on the other pair catch in that same cycle. A corrupted fold first appears as a true/complement pair whose change per strobe no longer XORs to zero or all ones. The single-flip tests and the whole-page comparisons against an independent bit-by-bit model also catch such a fault in the final words of the page.

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter int BYTE_W   = 8,
  parameter int CHUNK_AW = 8,
  localparam int BIT_AW  = $clog2(BYTE_W),
  localparam int PW      = CHUNK_AW + BIT_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              big_page_i,
  output logic [PW-1:0]     lo_true_o,
  output logic [PW-1:0]     lo_comp_o,
  output logic [PW-1:0]     hi_true_o,
  output logic [PW-1:0]     hi_comp_o
);

  logic [CHUNK_AW:0] cnt;
  logic [PW-1:0]     fold_t, fold_c;
  logic              upper;

  assign upper = big_page_i & cnt[CHUNK_AW];

  always_comb begin
    fold_t = '0;
    fold_c = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      if (byte_i[b]) begin
        fold_t = fold_t ^ {cnt[CHUNK_AW-1:0], BIT_AW'(b)};
        fold_c = fold_c ^ ~{cnt[CHUNK_AW-1:0], BIT_AW'(b)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      lo_true_o <= '0;
      lo_comp_o <= '0;
      hi_true_o <= '0;
      hi_comp_o <= '0;
    end else if (clr_i) begin
      cnt       <= '0;
      lo_true_o <= '0;
      lo_comp_o <= '0;
      hi_true_o <= '0;
      hi_comp_o <= '0;
    end else if (byte_vld_i) begin
      cnt <= cnt + 1'b1;
      if (upper) begin
        hi_true_o <= hi_true_o ^ fold_t;
        hi_comp_o <= hi_comp_o ^ fold_c;
      end else begin
        lo_true_o <= lo_true_o ^ fold_t;
        lo_comp_o <= lo_comp_o ^ fold_c;
      end
    end
  end

endmodule

module nand_ecc_gen_chk #(
  parameter int PW       = 11,
  parameter int CHUNK_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              byte_vld_i,
  input logic              big_page_i,
  input logic [CHUNK_AW:0] cnt,
  input logic [PW-1:0]     lo_true_o,
  input logic [PW-1:0]     lo_comp_o,
  input logic [PW-1:0]     hi_true_o,
  input logic [PW-1:0]     hi_comp_o
);
  localparam logic [PW-1:0] ONES = {PW{1'b1}};

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (lo_true_o == '0 && lo_comp_o == '0 && hi_true_o == '0 &&
               hi_comp_o == '0 && cnt == '0));

  assert_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && byte_vld_i) |=>
      (((lo_true_o ^ $past(lo_true_o)) ^ (lo_comp_o ^ $past(lo_comp_o))) == '0 ||
       ((lo_true_o ^ $past(lo_true_o)) ^ (lo_comp_o ^ $past(lo_comp_o))) == ONES) &&
      (((hi_true_o ^ $past(hi_true_o)) ^ (hi_comp_o ^ $past(hi_comp_o))) == '0 ||
       ((hi_true_o ^ $past(hi_true_o)) ^ (hi_comp_o ^ $past(hi_comp_o))) == ONES));

  assert_low_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && byte_vld_i && big_page_i && !cnt[CHUNK_AW]) |=>
      ($stable(hi_true_o) && $stable(hi_comp_o)));

  assert_high_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && byte_vld_i && big_page_i && cnt[CHUNK_AW]) |=>
      ($stable(lo_true_o) && $stable(lo_comp_o)));

  assert_small_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !big_page_i) |=> ($stable(hi_true_o) && $stable(hi_comp_o)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !byte_vld_i) |=>
      ($stable(lo_true_o) && $stable(lo_comp_o) && $stable(hi_true_o) &&
       $stable(hi_comp_o) && $stable(cnt)));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && byte_vld_i) |=> (cnt == $past(cnt) + 1'b1));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.PW(PW), .CHUNK_AW(CHUNK_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .byte_vld_i(byte_vld_i),
  .big_page_i(big_page_i), .cnt(cnt), .lo_true_o(lo_true_o),
  .lo_comp_o(lo_comp_o), .hi_true_o(hi_true_o), .hi_comp_o(hi_comp_o)
);

// File: tb/test_nand_ecc_gen.sv
module test_nand_ecc_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0;
  logic byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic big_page_i = 1'b0;
  logic [10:0] lo_true_o, lo_comp_o, hi_true_o, hi_comp_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [10:0] mt [2];
  logic [10:0] mc [2];
  int mcnt;

  always #10 clk = ~clk;

  nand_ecc_gen i_nand_ecc_gen (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .big_page_i(big_page_i), .lo_true_o(lo_true_o),
    .lo_comp_o(lo_comp_o), .hi_true_o(hi_true_o), .hi_comp_o(hi_comp_o)
  );

  // {big page, short run, seed}
  localparam logic [9:0] VEC [0:7] = '{
    {1'b0, 1'b0, 8'h01}, {1'b0, 1'b0, 8'hA5}, {1'b1, 1'b0, 8'h37},
    {1'b1, 1'b0, 8'hFF}, {1'b0, 1'b1, 8'h5C}, {1'b1, 1'b1, 8'h00},
    {1'b1, 1'b0, 8'h80}, {1'b0, 1'b0, 8'h13}
  };

  function automatic logic [7:0] gen(input logic [7:0] s, input int i);
    return 8'(i * s) ^ 8'(i >> 3) ^ s;
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    mt[0] = '0; mt[1] = '0; mc[0] = '0; mc[1] = '0; mcnt = 0;
  endtask

  task automatic do_clear();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    clear_model();
  endtask

  task automatic put(input logic [7:0] d);
    int h;
    logic [10:0] a;
    byte_vld_i = 1'b1;
    byte_i = d;
    h = (big_page_i && mcnt >= 256) ? 1 : 0;
    for (int b = 0; b < 8; b++) begin
      if (d[b]) begin
        a = {8'(mcnt % 256), 3'(b)};
        mt[h] = mt[h] ^ a;
        mc[h] = mc[h] ^ ~a;
      end
    end
    mcnt = (mcnt + 1) % 512;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic check_model(input string tag_lo, input string tag_hi);
    check({tag_lo, " true lo"}, lo_true_o, mt[0]);
    check({tag_lo, " comp lo"}, lo_comp_o, mc[0]);
    check({tag_hi, " true hi"}, hi_true_o, mt[1]);
    check({tag_hi, " comp hi"}, hi_comp_o, mc[1]);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [10:0] t0, c0, t1, c1, h0, hc0;
    clear_model();
    repeat (3) @(negedge clk);
    check("R1 reset true lo", lo_true_o, 11'h000);
    check("R1 reset comp lo", lo_comp_o, 11'h000);
    check("R1 reset true hi", hi_true_o, 11'h000);
    check("R1 reset comp hi", hi_comp_o, 11'h000);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2, R3, R4, R5
    for (int v = 0; v < 8; v++) begin
      big_page_i = VEC[v][9];
      do_clear();
      for (int i = 0; i < (VEC[v][8] ? 37 : (VEC[v][9] ? 512 : 256)); i++)
        put(gen(VEC[v][7:0], i));
      check_model(VEC[v][9] ? "R4 R2 R3" : "R2 R3",
                  VEC[v][9] ? "R4" : "R5");
    end

    // R6: one byte visible one clock after strobe, then idle hold
    big_page_i = 1'b0;
    do_clear();
    put(8'h02);
    check("R6 update next cycle", lo_true_o, 11'h001);
    check("R6 update next cycle comp", lo_comp_o, 11'h7FE);
    repeat (5) @(negedge clk);
    check("R6 idle hold true", lo_true_o, 11'h001);
    check("R6 idle hold comp", lo_comp_o, 11'h7FE);

    // R5: long run in small page mode wraps index, high pair stays zero
    do_clear();
    for (int i = 0; i < 300; i++) put(gen(8'h6B, i));
    check_model("R5", "R5");
    check("R5 hi zero", hi_true_o | hi_comp_o, 11'h000);

    // R7: clear together with strobe
    for (int i = 0; i < 5; i++) put(8'hFF);
    clr_i = 1'b1;
    byte_vld_i = 1'b1;
    byte_i = 8'hFF;
    @(negedge clk);
    clr_i = 1'b0;
    byte_vld_i = 1'b0;
    clear_model();
    check("R7 clear wins true", lo_true_o, 11'h000);
    check("R7 clear wins comp", lo_comp_o, 11'h000);
    put(8'h01);
    check("R7 next index zero true", lo_true_o, 11'h000);
    check("R7 next index zero comp", lo_comp_o, 11'h7FF);

    // R8: single flipped bit, low chunk (byte 77 bit 5)
    big_page_i = 1'b1;
    do_clear();
    for (int i = 0; i < 512; i++) put(gen(8'h29, i));
    t0 = lo_true_o; c0 = lo_comp_o; h0 = hi_true_o; hc0 = hi_comp_o;
    do_clear();
    for (int i = 0; i < 512; i++) put(gen(8'h29, i) ^ ((i == 77) ? 8'h20 : 8'h00));
    t1 = lo_true_o; c1 = lo_comp_o;
    check("R8 flip address", t0 ^ t1, {8'd77, 3'd5});
    check("R8 flip syndrome", (t0 ^ t1) ^ (c0 ^ c1), 11'h7FF);
    check("R8 other half untouched", hi_true_o, h0);
    // R8 / R4: flip in upper half, byte 300 -> index 44, bit 2
    do_clear();
    for (int i = 0; i < 512; i++) put(gen(8'h29, i) ^ ((i == 300) ? 8'h04 : 8'h00));
    check("R8 R4 upper flip address", h0 ^ hi_true_o, {8'd44, 3'd2});
    check("R8 R4 upper flip syndrome", (h0 ^ hi_true_o) ^ (hc0 ^ hi_comp_o), 11'h7FF);
    check("R8 R4 upper flip low intact", lo_true_o, t0);

    // R9: wrap after 512 strobes
    do_clear();
    for (int i = 0; i < 512; i++) put(8'h00);
    put(8'h80);
    check("R9 wrap true lo", lo_true_o, 11'h007);
    check("R9 wrap comp lo", lo_comp_o, 11'h7F8);
    check("R9 wrap hi", hi_true_o | hi_comp_o, 11'h000);

    // R1: asynchronous reset mid-page
    rst_n = 1'b0;
    #3;
    check("R1 async reset true lo", lo_true_o, 11'h000);
    check("R1 async reset comp lo", lo_comp_o, 11'h000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule